// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter

This block decides which of several masters may drive a shared bus. Each master has a front-end. When the local client pulses a start strobe, the front-end raises its request line and holds it. A central fixed-priority arbiter gives a grant to one requesting master at a time.

A granted master does not take the bus at once. It waits until the shared busy line is low. It then raises its own busy output and drops its request in the same cycle. The arbiter sees that the granted master has taken the bus and withdraws the grant one cycle later. After that, the arbiter may grant the next requester while the current owner is still busy.

The owner keeps busy high for the transfer length it captured when it made its request, then lets go of the bus. The shared busy line is the OR of every front-end's busy output. Data movement and address decode are left to the clients.

Top module: `bus_own_arbiter`

## Requirements
- R1: A start strobe `want_i[i]` seen while front-end i is idle (neither requesting nor owning) raises `br_o[i]` on the next clock edge. `br_o[i]` stays high until the front-end owns the bus.
- R2: When no grant is outstanding, the arbiter grants the requesting front-end with the lowest index, one edge after it sees the request. Bit i of `bg_o` belongs to front-end i. Masters that request together become owners in ascending index order.
- R3: At most one bit of `bg_o` is high in any cycle.
- R4: Front-end i becomes owner (`own_o[i]` high, `br_o[i]` low) on the edge where `bg_o[i]` is high and `bb_o` is low. It never takes the bus while `bb_o` is high, and at most one front-end owns the bus at a time.
- R5: A grant bit whose front-end is seen owning the bus is cleared on the following edge.
- R6: An owner keeps `own_o[i]` high for exactly L cycles. L is the 4-bit field `len_i[i*LEN_W +: LEN_W]` captured on the edge that accepted the start strobe; a captured value of 0 acts as 1. Later changes to `len_i` have no effect on a transfer already requested.
- R7: `bb_o` is high exactly when some `own_o` bit is high.
- R8: A master may be granted while another master still owns the bus. It then takes the bus one cycle after `bb_o` falls, which leaves a single idle cycle.
- R9: A start strobe that arrives while a front-end is requesting or owning is ignored. It produces no further request and no further ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| want_i | input | NUM_REQ | Per-master start strobe |
| len_i | input | NUM_REQ*LEN_W | Per-master transfer length, field i at bits i*LEN_W |
| br_o | output | NUM_REQ | Bus request per master |
| bg_o | output | NUM_REQ | Bus grant per master |
| bb_o | output | 1 | Shared bus busy (OR of owners) |
| own_o | output | NUM_REQ | Per-master busy / ownership |

## Verification
Each result is due at a fixed distance from the strobe on an idle bus. Counting the strobe edge as edge 1, the request appears after edge 1, the grant after edge 2, ownership after edge 3, and the grant is withdrawn after edge 4. The bench samples on falling edges and checks each of these in its own half-cycle. A queue holds the expected owner order and lengths, and a monitor compares every ownership rise and fall against it. For grants issued while the bus is busy, the monitor requires the new owner to rise exactly one cycle after busy falls.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_REQ  = 2'd1,
    FE_OWN  = 2'd2
  } fe_state_e;
endpackage

// File: rtl/bus_req_fe.sv
module bus_req_fe
  import bus_arb_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             want_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             bg_i,
  input  logic             bb_i,
  output logic             br_o,
  output logic             own_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  fe_state_e        state_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FE_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        FE_IDLE: if (want_i) begin
          state_q <= FE_REQ;
          cnt_q   <= (len_i == '0) ? ONE : len_i;
        end
        // wait for grant and an idle bus before claiming it
        FE_REQ: if (bg_i && !bb_i) state_q <= FE_OWN;
        FE_OWN: begin
          if (cnt_q == ONE) state_q <= FE_IDLE;
          else              cnt_q   <= cnt_q - ONE;
        end
        default: state_q <= FE_IDLE;
      endcase
    end
  end

  assign br_o  = (state_q == FE_REQ);
  assign own_o = (state_q == FE_OWN);
endmodule

// File: rtl/bus_prio_grant.sv
module bus_prio_grant #(
  parameter int NUM_REQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] br_i,
  input  logic [NUM_REQ-1:0] own_i,
  output logic [NUM_REQ-1:0] bg_o
);
  logic [NUM_REQ-1:0] gnt_q, gnt_d, pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (br_i[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (gnt_q != '0) gnt_d = ((gnt_q & own_i) != '0) ? '0 : gnt_q;
    else             gnt_d = pick;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gnt_q <= '0;
    else         gnt_q <= gnt_d;
  end

  assign bg_o = gnt_q;
endmodule

// File: rtl/bus_own_arbiter.sv
module bus_own_arbiter #(
  parameter int NUM_REQ = 4,
  parameter int LEN_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_REQ-1:0]       want_i,
  input  logic [NUM_REQ*LEN_W-1:0] len_i,
  output logic [NUM_REQ-1:0]       br_o,
  output logic [NUM_REQ-1:0]       bg_o,
  output logic                     bb_o,
  output logic [NUM_REQ-1:0]       own_o
);
  logic [NUM_REQ-1:0] br_w, own_w, bg_w;

  bus_prio_grant #(.NUM_REQ(NUM_REQ)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .br_i   (br_w),
    .own_i  (own_w),
    .bg_o   (bg_w)
  );

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_fe
    bus_req_fe #(.LEN_W(LEN_W)) u_fe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .want_i (want_i[g]),
      .len_i  (len_i[g*LEN_W +: LEN_W]),
      .bg_i   (bg_w[g]),
      .bb_i   (bb_o),
      .br_o   (br_w[g]),
      .own_o  (own_w[g])
    );
  end

  // wired-OR busy line
  assign bb_o  = |own_w;
  assign br_o  = br_w;
  assign bg_o  = bg_w;
  assign own_o = own_w;
endmodule

// File: rtl/bus_own_arbiter_chk.sv
module bus_own_arbiter_chk #(
  parameter int NUM_REQ = 4,
  parameter int LEN_W   = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_REQ-1:0]       want_i,
  input logic [NUM_REQ*LEN_W-1:0] len_i,
  input logic [NUM_REQ-1:0]       br_o,
  input logic [NUM_REQ-1:0]       bg_o,
  input logic                     bb_o,
  input logic [NUM_REQ-1:0]       own_o
);
  logic [NUM_REQ-1:0] low_br;
  assign low_br = br_o & (~br_o + NUM_REQ'(1));

  assert_one_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bg_o));

  assert_one_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own_o));

  assert_prio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bg_o == '0 && br_o != '0) |=> (bg_o == $past(low_br)));

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_chk
    assert_req_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (want_i[i] && !br_o[i] && !own_o[i]) |=> br_o[i]);

    assert_take_rule_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(own_o[i]) |-> ($past(bg_o[i]) && !$past(bb_o)));

    assert_br_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_o[i] |-> !br_o[i]);

    assert_bg_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bg_o[i] && own_o[i]) |=> !bg_o[i]);
  end
endmodule

bind bus_own_arbiter bus_own_arbiter_chk #(.NUM_REQ(NUM_REQ), .LEN_W(LEN_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .want_i (want_i),
  .len_i  (len_i),
  .br_o   (br_o),
  .bg_o   (bg_o),
  .bb_o   (bb_o),
  .own_o  (own_o)
);

// File: tb/bus_own_arbiter_test.sv
module bus_own_arbiter_test;
  localparam int N  = 4;
  localparam int LW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    want = '0;
  logic [N*LW-1:0] len = '0;
  logic [N-1:0]    br_o, bg_o, own_o;
  logic            bb_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_fall = 0;

  typedef struct { int idx; int len; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  bus_own_arbiter #(.NUM_REQ(N), .LEN_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .want_i(want), .len_i(len),
    .br_o(br_o), .bg_o(bg_o), .bb_o(bb_o), .own_o(own_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic expect_own(input int idx, input int l);
    exp_t e;
    e.idx = idx;
    e.len = (l == 0) ? 1 : l;
    sb_q.push_back(e);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // driver: set strobes and lengths at a falling edge, clear after one cycle
  task automatic drive(input logic [N-1:0] mask, input int l0, input int l1,
                       input int l2, input int l3);
    int ls[N];
    ls[0] = l0; ls[1] = l1; ls[2] = l2; ls[3] = l3;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        len[i*LW +: LW] = LW'(ls[i]);
        expect_own(i, ls[i]);
      end
    end
    want = mask;
    step();
    want = '0;
    len  = '1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200; k++) begin
      step();
      if (own_o == '0 && br_o == '0 && bg_o == '0 && sb_q.size() == 0) break;
    end
    chk(sb_q.size() == 0, "R2", sb_q.size(), 0);
  endtask

  // monitor / scoreboard
  logic [N-1:0] prev_own, prev_bg, waited;
  logic         prev_bb;
  int           run[N];
  int           exp_len[N];

  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      prev_own = '0; prev_bg = '0; prev_bb = 1'b0; waited = '0;
    end else begin
      cyc++;
      chk($onehot0(bg_o), "R3", int'(bg_o), 0);
      chk(bb_o == |own_o, "R7", int'(bb_o), int'(|own_o));
      for (int i = 0; i < N; i++) begin
        if (own_o[i] && !prev_own[i]) begin
          chk(prev_bg[i] && !prev_bb, "R4", int'(prev_bb), 0);
          chk(!br_o[i], "R4", int'(br_o[i]), 0);
          if (waited[i]) chk(cyc == last_fall + 1, "R8", cyc - last_fall, 1);
          waited[i] = 1'b0;
          if (sb_q.size() == 0) chk(1'b0, "R9", i, -1);
          else begin
            e = sb_q.pop_front();
            chk(e.idx == i, "R2", i, e.idx);
            exp_len[i] = e.len;
          end
          run[i] = 1;
        end else if (own_o[i]) begin
          run[i]++;
        end else if (prev_own[i]) begin
          chk(run[i] == exp_len[i], "R6", run[i], exp_len[i]);
          last_fall = cyc;
        end
        if (prev_bg[i] && prev_own[i]) chk(!bg_o[i], "R5", int'(bg_o[i]), 0);
        if (bg_o[i] && bb_o && !own_o[i]) waited[i] = 1'b1;
      end
      prev_own = own_o; prev_bg = bg_o; prev_bb = bb_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk(br_o == '0 && bg_o == '0 && own_o == '0 && !bb_o, "R1", int'(own_o), 0);
    rst_n = 1'b1;
    repeat (2) step();

    // single request: exact cycle of each result
    drive(4'b0001, 3, 0, 0, 0);
    chk(br_o[0], "R1", int'(br_o[0]), 1);
    step();
    chk(bg_o[0], "R2", int'(bg_o[0]), 1);
    step();
    chk(own_o[0] && !br_o[0], "R4", int'(own_o[0]), 1);
    chk(bb_o, "R7", int'(bb_o), 1);
    step();
    chk(!bg_o[0], "R5", int'(bg_o[0]), 0);
    // strobe while owning must be ignored
    len[0 +: LW] = 4'd7;
    want = 4'b0001;
    step();
    want = '0;
    chk(!br_o[0], "R9", int'(br_o[0]), 0);
    wait_idle();
    repeat (3) step();
    chk(br_o == '0 && own_o == '0, "R9", int'(own_o), 0);

    // simultaneous requests, length 0 acts as 1
    drive(4'b0111, 2, 3, 0, 0);
    wait_idle();

    // lower indices arrive while index 3 owns the bus
    drive(4'b1000, 0, 0, 0, 5);
    repeat (3) step();
    drive(4'b0110, 0, 2, 1, 0);
    wait_idle();

    // all masters, maximum length
    drive(4'b1111, 1, 4, 2, 15);
    wait_idle();

    repeat (4) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule